// File: doc/BRIEF.md
# Asynchronous Static RAM Transaction Sequencer

This block lets synchronous logic run single reads and writes against an external asynchronous static RAM. The host raises a request with a direction flag, an address and, for writes, the data, and holds it until a one-cycle acknowledge comes back. A read returns its data with that acknowledge. On the memory side the block drives the address bus, an active-low write strobe and an active-low output enable, and it owns one direction of a shared bidirectional data bus.

Every transaction runs through clock-cycle phases: address setup, then either a write-strobe window or an output-enable access window, then a one-cycle completion. The length of each phase is worked out at elaboration from the clock period and the memory's timing figures, all given in picoseconds. A phase takes the required time divided by the clock period, rounded up, and never less than one cycle. The setup phase gives the address and write data a head start, so the later phases only have to cover the time that is still missing. After the output enable goes high, a turnaround counter keeps the controller off the data bus until the memory's worst-case release time has passed.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after a synchronous reset, `mem_we_n` and `mem_oe_n` are high, the data bus is not driven, `host_ack` is low and the controller is idle.
- R2: Each phase lasts max(1, ceil(t_ps / CLK_PS)) cycles. The setup phase uses the address-to-strobe figure. The strobe phase uses the largest of the strobe-low minimum and the parts of the address and data setup-before-rise that the setup phase does not already cover. The access phase uses the larger of the part of the address access time that the setup phase does not cover and the output-enable access time. The turnaround uses the output-release time.
- R3: In a write, `mem_oe_n` stays high the whole time. `mem_we_n` is low for exactly the strobe-phase count. Before `mem_we_n` rises, the address and the driven data have been stable for at least the address and data setup times.
- R4: In a read, `mem_oe_n` is low for exactly the access-phase count. The bus is sampled at the clock edge that ends the last access cycle, and that value appears on `host_rdata` together with the acknowledge.
- R5: After `mem_oe_n` rises, the controller does not drive the data bus for the turnaround count of cycles. A write issued right after a read therefore drops `mem_we_n` no earlier than turnaround plus setup cycles after `mem_oe_n` rose.
- R6: `host_ack` is high for exactly one cycle per transaction. That cycle is the first cycle with `mem_we_n` back high (write) or `mem_oe_n` back high (read).
- R7: The direction, address and write data are sampled only when an idle controller accepts a request. Changes to them while a transaction is in progress have no effect on `mem_addr`, on the stored data or on the returned data.
- R8: The data bus is driven only during the setup and strobe phases of a write, and never while `mem_oe_n` is low.
- R9: `mem_we_n` and `mem_oe_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PS picoseconds |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Transaction request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Memory address |
| host_wdata | input | DATA_W | Data to write |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Data captured by the last read |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_we_n | output | 1 | Write strobe, active low, data stored on its rise |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The bench's memory model measures the strobe-low time and the address and data ages at the rising strobe edge in real time. It drives inverted data until both read access limits have passed. An access phase one cycle too short therefore returns wrong data, and a strobe that is too short is flagged. A write issued straight after a read exposes a missing turnaround, because the write strobe would then fall a cycle too early. Host fields are scrambled in mid-transaction, so a controller that samples them after acceptance writes to the wrong address or returns the wrong data. The acknowledge is also checked against the strobe and output-enable rises, which catches an acknowledge that comes a cycle early or late.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_ACCESS = 3'd3,
      PH_DONE   = 3'd4
   } phase_e;

   // whole cycles covering a time span, never below one
   function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                             input int unsigned clk_ps);
      int unsigned c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   // time still owed after an earlier phase already elapsed
   function automatic int unsigned owed_ps(input int unsigned need_ps,
                                           input int unsigned spent_ps);
      return (need_ps > spent_ps) ? (need_ps - spent_ps) : 0;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 1) else $error("sram_phase_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_turn_guard.sv
`timescale 1ns/1ps
module sram_turn_guard #(
   parameter int unsigned TURN_CYC = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   output logic busy
);
   initial begin
      assert (TURN_CYC >= 1) else $error("sram_turn_guard: TURN_CYC must be at least 1");
   end

   generate
      if (TURN_CYC == 1) begin : g_single
         logic hold_q;
         always_ff @(posedge clk) begin
            if (rst) hold_q <= 1'b0;
            else     hold_q <= arm;
         end
         assign busy = hold_q;
      end else begin : g_count
         localparam int unsigned TW = $clog2(TURN_CYC + 1);
         logic [TW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (rst)
               left_q <= '0;
            else if (arm)
               left_q <= TW'(TURN_CYC);
            else if (left_q != '0)
               left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              drive,
   input  logic [DATA_W-1:0] wdata,
   input  logic              capture,
   output logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] dq
);
   logic [DATA_W-1:0] rdata_q;

   assign dq = drive ? wdata : {DATA_W{1'bz}};

   always_ff @(posedge clk) begin
      if (rst)          rdata_q <= '0;
      else if (capture) rdata_q <= dq;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CLK_PS       = 8000,
   parameter int unsigned T_AS_PS      = 0,      // address before strobe fall
   parameter int unsigned T_WLOW_PS    = 8000,   // strobe low minimum
   parameter int unsigned T_AW_PS      = 10000,  // address before strobe rise
   parameter int unsigned T_DW_PS      = 6000,   // data before strobe rise
   parameter int unsigned T_AACC_PS    = 12000,  // address to valid read data
   parameter int unsigned T_OACC_PS    = 6000,   // enable to valid read data
   parameter int unsigned T_OHIZ_PS    = 6000    // bus release after enable off
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   inout  wire  [DATA_W-1:0] mem_dq
);
   localparam int unsigned SETUP_CYC = ps_to_cyc(T_AS_PS, CLK_PS);
   localparam int unsigned SETUP_PS  = SETUP_CYC * CLK_PS;
   localparam int unsigned WSTB_CYC  = ps_to_cyc(
      max2(T_WLOW_PS, max2(owed_ps(T_AW_PS, SETUP_PS), owed_ps(T_DW_PS, SETUP_PS))), CLK_PS);
   localparam int unsigned RD_CYC    = ps_to_cyc(
      max2(owed_ps(T_AACC_PS, SETUP_PS), T_OACC_PS), CLK_PS);
   localparam int unsigned TURN_CYC  = ps_to_cyc(T_OHIZ_PS, CLK_PS);
   localparam int unsigned CNT_MAX   = max2(SETUP_CYC, max2(WSTB_CYC, RD_CYC));
   localparam int unsigned CNT_W     = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] WSTB_LD  = CNT_W'(WSTB_CYC - 1);
   localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);

   initial begin
      assert (CLK_PS > 0) else $error("sram_seq_ctrl: CLK_PS must be positive");
      assert (ADDR_W > 0) else $error("sram_seq_ctrl: ADDR_W must be positive");
      assert (DATA_W > 0) else $error("sram_seq_ctrl: DATA_W must be positive");
   end

   phase_e            state_q, state_d;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              latch;
   logic              t_load, t_tick, t_last;
   logic [CNT_W-1:0]  t_val;
   logic              capture, turn_arm, turn_busy;
   logic              dq_drive;

   // sequencing
   always_comb begin
      state_d  = state_q;
      latch    = 1'b0;
      t_load   = 1'b0;
      t_val    = '0;
      t_tick   = 1'b0;
      capture  = 1'b0;
      turn_arm = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            if (host_req) begin
               state_d = PH_SETUP;
               latch   = 1'b1;
               t_load  = 1'b1;
               t_val   = SETUP_LD;
            end
         end
         PH_SETUP: begin
            t_tick = !(wr_q && turn_busy);
            if (t_tick && t_last) begin
               t_load = 1'b1;
               if (wr_q) begin
                  state_d = PH_STROBE;
                  t_val   = WSTB_LD;
               end else begin
                  state_d = PH_ACCESS;
                  t_val   = RD_LD;
               end
            end
         end
         PH_STROBE: begin
            t_tick = 1'b1;
            if (t_last) state_d = PH_DONE;
         end
         PH_ACCESS: begin
            t_tick = 1'b1;
            if (t_last) begin
               state_d  = PH_DONE;
               capture  = 1'b1;
               turn_arm = 1'b1;
            end
         end
         PH_DONE: state_d = PH_IDLE;
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PH_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (latch) begin
            wr_q    <= host_wr;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
         end
      end
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .tick     (t_tick),
      .last     (t_last)
   );

   sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
      .clk  (clk),
      .rst  (rst),
      .arm  (turn_arm),
      .busy (turn_busy)
   );

   assign dq_drive = wr_q && (((state_q == PH_SETUP) && !turn_busy) || (state_q == PH_STROBE));

   sram_dq_path #(.DATA_W(DATA_W)) u_dq (
      .clk     (clk),
      .rst     (rst),
      .drive   (dq_drive),
      .wdata   (wdata_q),
      .capture (capture),
      .rdata   (host_rdata),
      .dq      (mem_dq)
   );

   assign mem_addr = addr_q;
   assign mem_we_n = (state_q != PH_STROBE);
   assign mem_oe_n = (state_q != PH_ACCESS);
   assign host_ack = (state_q == PH_DONE);

   // checks beside the logic they guard
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (mem_we_n && mem_oe_n && !dq_drive && !host_ack));

   assert_capture_under_oe_R4: assert property (@(posedge clk) disable iff (rst)
      capture |-> !mem_oe_n);

   assert_turn_release_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_oe_n) |-> (turn_busy && !dq_drive));

   assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> !host_ack);

   assert_addr_held_R7: assert property (@(posedge clk) disable iff (rst)
      ((state_q != PH_IDLE) && ($past(state_q) != PH_IDLE)) |-> $stable(mem_addr));

   assert_no_drive_in_read_R8: assert property (@(posedge clk) disable iff (rst)
      !(dq_drive && !mem_oe_n));

   assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
      !(!mem_we_n && !mem_oe_n));

endmodule

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;
   localparam int AW     = 8;
   localparam int DW     = 8;
   localparam int CLK_PS = 8000;
   localparam int TAS    = 0;
   localparam int TWL    = 20000;
   localparam int TAW    = 10000;
   localparam int TDW    = 6000;
   localparam int TAA    = 12000;
   localparam int TOA    = 9000;
   localparam int THZ    = 20000;

   // expected phase lengths from the timing figures (R2)
   localparam int E_SETUP = 1;                       // 0 ps rounds up to the one-cycle floor
   localparam int E_WSTB  = (TWL + CLK_PS - 1) / CLK_PS;          // 20 ns dominates: 3
   localparam int E_RD    = (TOA + CLK_PS - 1) / CLK_PS;          // 9 ns > 12-8 ns: 2
   localparam int E_TURN  = (THZ + CLK_PS - 1) / CLK_PS;          // 3

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] haddr = '0;
   logic [DW-1:0] hwdata = '0;
   wire           ack;
   wire  [DW-1:0] rdata;
   wire  [AW-1:0] mem_addr;
   wire           we_n;
   wire           oe_n;
   wire  [DW-1:0] mem_dq;

   sram_seq_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .T_AS_PS(TAS), .T_WLOW_PS(TWL),
      .T_AW_PS(TAW), .T_DW_PS(TDW), .T_AACC_PS(TAA), .T_OACC_PS(TOA), .T_OHIZ_PS(THZ)
   ) u0 (
      .clk(clk), .rst(rst), .host_req(req), .host_wr(wr), .host_addr(haddr),
      .host_wdata(hwdata), .host_ack(ack), .host_rdata(rdata), .mem_addr(mem_addr),
      .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq(mem_dq)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] mdl_mem [256];
   logic [DW-1:0] ref_mem [256];
   realtime t_addr = 0, t_wf = 0, t_oef = 0, t_dq = 0;
   logic    vld = 1'b0;
   bit      armed = 0;

   always @(mem_addr)    t_addr = $realtime;
   always @(mem_dq)      t_dq   = $realtime;
   always @(negedge oe_n) t_oef = $realtime;
   always @(negedge we_n) begin t_wf = $realtime; armed = 1; end

   wire [DW-1:0] mdl_out = vld ? mdl_mem[mem_addr] : ~mdl_mem[mem_addr];
   assign mem_dq = (!oe_n && we_n) ? mdl_out : {DW{1'bz}};

   initial begin
      logic [AW-1:0] s_addr;
      logic [DW-1:0] s_dq;
      realtime s_ta, s_td, rise;
      bit oe_bad, we_prev;
      oe_bad = 0; we_prev = 1; s_addr = '0; s_dq = '0; s_ta = 0; s_td = 0;
      for (int i = 0; i < 256; i++) mdl_mem[i] = 8'(i * 7 + 3);
      #0.5;
      forever begin
         vld = !oe_n && (($realtime - t_addr) >= TAA / 1000.0)
                     && (($realtime - t_oef) >= TOA / 1000.0);
         if (!we_n) begin
            s_addr = mem_addr; s_dq = mem_dq; s_ta = t_addr; s_td = t_dq;
            if (!oe_n) oe_bad = 1;
         end else if (!we_prev && armed) begin
            rise = $realtime - 0.5;
            chk((rise - t_wf) >= TWL / 1000.0, "R3 strobe low time ns", int'(rise - t_wf), TWL / 1000);
            chk((rise - s_ta) >= TAW / 1000.0, "R3 address age at strobe rise ns", int'(rise - s_ta), TAW / 1000);
            chk((rise - s_td) >= TDW / 1000.0, "R3 data age at strobe rise ns", int'(rise - s_td), TDW / 1000);
            chk(!oe_bad, "R3 output enable high during write", oe_bad, 0);
            mdl_mem[s_addr] = s_dq;
            oe_bad = 0;
         end
         we_prev = we_n;
         #1;
      end
   end

   // ---------------- scoreboard and port monitor ----------------
   logic [DW:0] sb_q[$];
   int  we_cnt = 0, oe_cnt = 0, since_oe = 1000;
   bit  saw_read = 0, ack_prev = 0, both_low = 0;

   always @(negedge clk) begin
      if (!rst) begin
         if (!we_n && !oe_n) both_low = 1;
         if (!we_n) begin
            if (we_cnt == 0 && saw_read)
               chk(since_oe >= E_TURN + E_SETUP, "R5 cycles from enable rise to strobe fall",
                   since_oe, E_TURN + E_SETUP);
            we_cnt++;
         end else if (we_cnt != 0) begin
            chk(we_cnt == E_WSTB, "R2 R3 strobe low cycles", we_cnt, E_WSTB);
            chk(ack, "R6 ack with strobe rise", ack, 1);
            we_cnt = 0;
         end
         if (!oe_n) begin
            oe_cnt++; since_oe = 0; saw_read = 1;
         end else begin
            if (oe_cnt != 0) begin
               chk(oe_cnt == E_RD, "R2 R4 enable low cycles", oe_cnt, E_RD);
               chk(ack, "R6 ack with enable rise", ack, 1);
               oe_cnt = 0;
            end
            if (since_oe < 1000) since_oe++;
         end
         if (ack) begin
            logic [DW:0] item;
            chk(!ack_prev, "R6 ack single cycle", ack_prev, 0);
            if (sb_q.size() == 0) begin
               chk(0, "R6 ack without request", 1, 0);
            end else begin
               item = sb_q.pop_front();
               if (!item[DW])
                  chk(rdata == item[DW-1:0], "R4 R7 R8 read data", rdata, item[DW-1:0]);
            end
         end
         ack_prev = ack;
      end
   end

   // ---------------- driver ----------------
   task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit scramble);
      int k;
      if (w) begin
         sb_q.push_back({1'b1, d});
         ref_mem[a] = d;
      end else begin
         sb_q.push_back({1'b0, ref_mem[a]});
      end
      req = 1'b1; wr = w; haddr = a; hwdata = d;
      k = 0;
      do begin
         @(negedge clk);
         k++;
         if (scramble && k == 2) begin
            haddr = ~a; hwdata = ~d; wr = !w;
         end
      end while (!ack);
      req = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      chk(we_n == 1'b1, "R1 strobe high in reset", we_n, 1);
      chk(oe_n == 1'b1, "R1 enable high in reset", oe_n, 1);
      rst = 1'b0;
      @(negedge clk);
      chk(we_n && oe_n, "R1 strobes idle after reset", {we_n, oe_n}, 3);
      chk(ack == 1'b0, "R1 no ack after reset", ack, 0);

      xfer(1, 8'h00, 8'hA5, 0);
      xfer(1, 8'hFF, 8'h3C, 0);
      xfer(1, 8'h55, 8'h00, 0);
      xfer(0, 8'h00, 8'h00, 0);
      xfer(0, 8'hFF, 8'h00, 0);
      xfer(0, 8'h55, 8'h00, 0);
      xfer(0, 8'h12, 8'h00, 0);
      // read followed at once by a write: turnaround window (R5)
      xfer(1, 8'h12, 8'hC3, 0);
      xfer(0, 8'h12, 8'h00, 0);
      xfer(1, 8'h40, 8'h5A, 0);
      xfer(0, 8'h40, 8'h00, 0);
      // host fields change in mid-transaction (R7)
      xfer(1, 8'h80, 8'h7E, 1);
      xfer(0, 8'h80, 8'h00, 1);
      xfer(0, 8'h7F, 8'h00, 0);
      repeat (3) @(negedge clk);
      for (int i = 0; i < 16; i++) xfer(1, 8'(i * 17), 8'(i * 29 + 1), 0);
      for (int i = 15; i >= 0; i--) xfer(0, 8'(i * 17), 8'h00, 0);
      repeat (6) @(negedge clk);
      chk(sb_q.size() == 0, "R6 every request acknowledged", sb_q.size(), 0);
      chk(!both_low, "R9 strobe and enable never both low", both_low, 0);
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog R6 transaction never completed actual=0 expected=1");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule